// File: doc/BRIEF.md
# Two-Stage Serial Clock Generator

This block derives a card serial clock from a fixed reference clock. An even pre-divider halves its programmed factor into two equal phases. A rate stage then lets one pre-divider period out of every (1 + rate) reach the output. The output period is therefore the divide factor times (1 + rate) reference cycles. Over one output period the block gives a one-cycle clock-enable pulse and a visible serial clock level. The level is high for the first half of the period's first pre-divider period and low for the rest.

A second function watches data transfers. A start strobe arms a counter that counts in units of 4096 reference cycles. When the programmed number of units has passed, a sticky timeout flag is raised. A stop strobe halts the count. A timeout value of zero leaves the counter idle.

Top module: `sclk_gen_top`

## Requirements
- R1: Consecutive pulses of `sclk_en` are exactly D*(1+R) reference cycles apart, where D is the effective divide factor and R is `rate_cfg`. `sclk_en` is high for exactly one cycle of each period.
- R2: `sclk_level` is 1 for the first D/2 cycles of each output period, counted from the cycle in which `sclk_en` is 1. It is 0 for the remaining cycles.
- R3: The effective divide factor D is `div_cfg` with bit 0 cleared. A `div_cfg` of 0 or 1 gives D = 2.
- R4: `div_cfg` and `rate_cfg` are sampled only at the last clock edge of an output period, and also during reset. A change at any other time does not alter the period in progress.
- R5: The timeout flag `tmo_flag` goes to 1 exactly `tmo_cfg`*4096 clock edges after the edge that samples `xfer_start`, provided no stop or start strobe arrives in between.
- R6: A `xfer_stop` strobe without `xfer_start` halts the count, and the flag does not rise afterwards.
- R7: A start strobe with `tmo_cfg` equal to 0 never raises the flag.
- R8: `tmo_flag` stays 1 until the next start strobe. A start strobe clears it and restarts the count from zero, even while a count is running. Start takes priority over stop in the same cycle.
- R9: After synchronous reset, the generator is at the first cycle of a period, so `sclk_en` = 1 and `sclk_level` = 1. `tmo_flag` is 0 and the counter is idle.
- R10: With D = 2 and R = 0, `sclk_level` alternates every cycle and `sclk_en` is 1 on each high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_cfg | input | 8 | Pre-divider factor (even, minimum 2) |
| rate_cfg | input | 8 | Rate stage factor, period multiplied by 1+value |
| tmo_cfg | input | 16 | Timeout limit in units of 4096 cycles, 0 disables |
| xfer_start | input | 1 | Start strobe: clears flag and restarts timeout count |
| xfer_stop | input | 1 | Stop strobe: halts timeout count |
| sclk_en | output | 1 | One-cycle pulse at the start of each output period |
| sclk_level | output | 1 | Serial clock level |
| tmo_flag | output | 1 | Sticky timeout flag |

## Verification
Suppose the pre-divider or rate counter holds a wrong value, or picks up a new setting in mid-period. The effect shows at `sclk_en` and `sclk_level` in the very next cycle in which a period or half-period should end, which is at most D*(1+R) cycles later. The reference model tracks the position within the current period. It is compared with the design on every cycle, so such a slip shows up in the first cycle that differs. A timeout count that is off by one unit edge, or that keeps running after a stop, shows as the flag rising a cycle early, a cycle late or not at all. The bench therefore uses short limits and compares the flag on every cycle across the whole window.

// File: rtl/sclk_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the two-stage serial clock generator.
// Assumes: widths here are defaults only; modules take them as parameters.
package sclk_pkg;
    localparam int unsigned SCLK_DIV_W     = 8;
    localparam int unsigned SCLK_RATE_W    = 8;
    localparam int unsigned SCLK_TMO_W     = 16;
    localparam int unsigned SCLK_UNIT_LOG2 = 12;

    // Half of a pre-divider period.
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } sclk_phase_e;
endpackage

// File: rtl/sclk_prediv.sv
`timescale 1ns/1ps
// Even pre-divider. It splits each period of D reference cycles into two phases of D/2.
// The divide setting is made even (minimum 2) and latched only when load is high.
// Assumes: load is asserted on the last cycle of an output period.
module sclk_prediv
    import sclk_pkg::*;
#(
    parameter int unsigned DIV_W = SCLK_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic             load,
    output logic             pre_end,
    output logic             first_half,
    output logic             at_start
);
    localparam int unsigned HALF_W = DIV_W - 1;

    logic [DIV_W-1:0]  div_eff;
    logic [HALF_W-1:0] half_act;
    logic [HALF_W-1:0] cnt;
    logic              half_end;
    sclk_phase_e       phase;

    // Round the divide setting down to even, with a floor of 2.
    always_comb begin
        if (div_cfg < DIV_W'(2)) div_eff = DIV_W'(2);
        else                     div_eff = {div_cfg[DIV_W-1:1], 1'b0};
    end

    assign half_end   = (cnt == half_act - HALF_W'(1));
    assign pre_end    = half_end && (phase == PH_SECOND);
    assign first_half = (phase == PH_FIRST);
    assign at_start   = (phase == PH_FIRST) && (cnt == '0);

    // Latch the half-period length at reset and at period boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)    half_act <= div_eff[DIV_W-1:1];
        else if (load) half_act <= div_eff[DIV_W-1:1];
    end

    // Count cycles within a half and flip phase at the end of each half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= PH_FIRST;
        end else if (half_end) begin
            cnt   <= '0;
            phase <= (phase == PH_FIRST) ? PH_SECOND : PH_FIRST;
        end else begin
            cnt   <= cnt + HALF_W'(1);
        end
    end

    p_half_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        half_act != '0);
    p_cnt_in_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < half_act);
    p_half_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(half_act));
endmodule

// File: rtl/sclk_rate_stage.sv
`timescale 1ns/1ps
// Rate stage. It counts pre-divider periods from 0 to the latched rate, and the output
// period ends when the count wraps. The rate setting is latched at that boundary only.
module sclk_rate_stage
    import sclk_pkg::*;
#(
    parameter int unsigned RATE_W = SCLK_RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_cfg,
    input  logic              pre_end,
    output logic              period_end,
    output logic              rate_zero
);
    logic [RATE_W-1:0] rate_act;
    logic [RATE_W-1:0] cnt;

    assign period_end = pre_end && (cnt == rate_act);
    assign rate_zero  = (cnt == '0);

    // Count pre-divider periods and reload the rate at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            rate_act <= rate_cfg;
        end else if (period_end) begin
            cnt      <= '0;
            rate_act <= rate_cfg;
        end else if (pre_end) begin
            cnt      <= cnt + RATE_W'(1);
        end
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= rate_act);
    p_rate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(rate_act));
endmodule

// File: rtl/sclk_timeout.sv
`timescale 1ns/1ps
// Data timeout counter. A start strobe clears the sticky flag, latches the limit and
// starts counting units of 2**UNIT_LOG2 cycles. A stop strobe halts it, and start wins.
// A limit of zero leaves the counter idle.
module sclk_timeout
    import sclk_pkg::*;
#(
    parameter int unsigned TMO_W     = SCLK_TMO_W,
    parameter int unsigned UNIT_LOG2 = SCLK_UNIT_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] tmo_cfg,
    input  logic             start,
    input  logic             stop,
    output logic             flag
);
    logic [UNIT_LOG2-1:0] unit_cnt;
    logic [TMO_W-1:0]     tick_cnt;
    logic [TMO_W-1:0]     limit;
    logic                 running;

    // Arm, halt or advance the count, and raise the flag on the final unit edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_cnt <= '0;
            tick_cnt <= '0;
            limit    <= '0;
            running  <= 1'b0;
            flag     <= 1'b0;
        end else if (start) begin
            unit_cnt <= '0;
            tick_cnt <= '0;
            limit    <= tmo_cfg;
            running  <= (tmo_cfg != '0);
            flag     <= 1'b0;
        end else if (stop) begin
            running  <= 1'b0;
        end else if (running) begin
            unit_cnt <= unit_cnt + UNIT_LOG2'(1);
            if (&unit_cnt) begin
                tick_cnt <= tick_cnt + TMO_W'(1);
                if (tick_cnt == limit - TMO_W'(1)) begin
                    flag    <= 1'b1;
                    running <= 1'b0;
                end
            end
        end
    end

    p_flag_from_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(running));
    p_stop_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !running);
    p_zero_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && tmo_cfg == '0) |=> (!running && !flag));
    p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !flag);
endmodule

// File: rtl/sclk_gen_top.sv
`timescale 1ns/1ps
// Two-stage serial clock generator top. It chains the even pre-divider and the rate
// stage, so the output period is D*(1+R) cycles, and it adds the data timeout counter.
// Assumes: the cfg inputs are quasi-static; they are sampled at period boundaries.
module sclk_gen_top
    import sclk_pkg::*;
#(
    parameter int unsigned DIV_W     = SCLK_DIV_W,
    parameter int unsigned RATE_W    = SCLK_RATE_W,
    parameter int unsigned TMO_W     = SCLK_TMO_W,
    parameter int unsigned UNIT_LOG2 = SCLK_UNIT_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic [RATE_W-1:0] rate_cfg,
    input  logic [TMO_W-1:0]  tmo_cfg,
    input  logic              xfer_start,
    input  logic              xfer_stop,
    output logic              sclk_en,
    output logic              sclk_level,
    output logic              tmo_flag
);
    logic pre_end;
    logic first_half;
    logic at_start;
    logic period_end;
    logic rate_zero;

    sclk_prediv #(.DIV_W(DIV_W)) u_prediv (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_cfg    (div_cfg),
        .load       (period_end),
        .pre_end    (pre_end),
        .first_half (first_half),
        .at_start   (at_start)
    );

    sclk_rate_stage #(.RATE_W(RATE_W)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_cfg   (rate_cfg),
        .pre_end    (pre_end),
        .period_end (period_end),
        .rate_zero  (rate_zero)
    );

    sclk_timeout #(.TMO_W(TMO_W), .UNIT_LOG2(UNIT_LOG2)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .tmo_cfg (tmo_cfg),
        .start   (xfer_start),
        .stop    (xfer_stop),
        .flag    (tmo_flag)
    );

    // The clock is passed only in the first pre-divider period of each output period.
    assign sclk_level = first_half && rate_zero;
    assign sclk_en    = at_start && rate_zero;

    p_en_is_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_en |-> sclk_level);
    p_end_then_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> sclk_en);
endmodule

// File: tb/test_sclk_gen_top.sv
`timescale 1ns/1ps
// Bench: a behavioural model tracks the position within the period and the elapsed timeout
// cycles, and it is compared with the design on every falling edge.
module test_sclk_gen_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_cfg = 8'd4;
    logic [7:0]  rate_cfg = 8'd1;
    logic [15:0] tmo_cfg = 16'd0;
    logic        xfer_start = 1'b0;
    logic        xfer_stop = 1'b0;
    logic        sclk_en, sclk_level, tmo_flag;

    int    checks = 0;
    int    errors = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string tag = "R9";

    always #2.5 clk = ~clk;

    sclk_gen_top i_sclk_gen_top (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .rate_cfg(rate_cfg),
        .tmo_cfg(tmo_cfg), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
        .sclk_en(sclk_en), .sclk_level(sclk_level), .tmo_flag(tmo_flag)
    );

    // Reference model state.
    int m_t = 0, m_d = 2, m_r = 0, m_el = 0, m_lim = 0;
    bit m_run = 1'b0, m_flag = 1'b0;

    function automatic int eff_div(int d);
        return (d < 2) ? 2 : (d & ~1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_t = 0; m_d = eff_div(div_cfg); m_r = rate_cfg;
            m_run = 0; m_flag = 0; m_el = 0; m_lim = 0;
        end else begin
            if (m_t == m_d * (m_r + 1) - 1) begin
                m_t = 0; m_d = eff_div(div_cfg); m_r = rate_cfg;
            end else begin
                m_t++;
            end
            if (xfer_start) begin
                m_el = 0; m_lim = tmo_cfg; m_run = (tmo_cfg != 0); m_flag = 0;
            end else if (xfer_stop) begin
                m_run = 0;
            end else if (m_run) begin
                m_el++;
                if (m_el == m_lim * 4096) begin m_flag = 1; m_run = 0; end
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(tag, "sclk_en", sclk_en, (m_t == 0));
            check(tag, "sclk_level", sclk_level, (m_t < m_d / 2));
            check(tag, "tmo_flag", tmo_flag, m_flag);
        end
    end

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        // R9: reset state observed before the first post-reset edge.
        check("R9", "en after reset", sclk_en, 1);
        check("R9", "level after reset", sclk_level, 1);
        check("R9", "flag after reset", tmo_flag, 0);
        cmp_on = 1'b1;
        tag = "R1"; cycles(37);
        tag = "R2"; cycles(20);
        // R4: mid-period change only takes effect at the boundary.
        tag = "R4"; cycles(3); div_cfg = 8'd2; rate_cfg = 8'd0; cycles(20);
        tag = "R10"; cycles(20);
        tag = "R3"; div_cfg = 8'd7; rate_cfg = 8'd2; cycles(60);
        div_cfg = 8'd1; rate_cfg = 8'd3; cycles(40);
        div_cfg = 8'd0; rate_cfg = 8'd0; cycles(20);
        tag = "R4"; div_cfg = 8'd10; rate_cfg = 8'd5; cycles(17);
        div_cfg = 8'd6; rate_cfg = 8'd1; cycles(150);
        tag = "R1"; div_cfg = 8'd3; rate_cfg = 8'd4; cycles(60);
        // R5: flag after 2*4096 cycles.
        tag = "R5"; tmo_cfg = 16'd2; pulse_start(); cycles(8200);
        check("R5", "flag raised", tmo_flag, 1);
        tag = "R8"; cycles(300);
        check("R8", "flag sticky", tmo_flag, 1);
        tmo_cfg = 16'd1; pulse_start();
        check("R8", "flag cleared by start", tmo_flag, 0);
        cycles(2000); pulse_start(); cycles(2500);
        check("R8", "retrigger delays flag", tmo_flag, 0);
        cycles(1700);
        check("R8", "flag after retrigger", tmo_flag, 1);
        // Start beats stop in the same cycle.
        xfer_start = 1'b1; xfer_stop = 1'b1; @(negedge clk);
        xfer_start = 1'b0; xfer_stop = 1'b0; cycles(4200);
        check("R8", "start wins over stop", tmo_flag, 1);
        tag = "R6"; pulse_start(); cycles(1000);
        xfer_stop = 1'b1; @(negedge clk); xfer_stop = 1'b0; cycles(5000);
        check("R6", "no flag after stop", tmo_flag, 0);
        tag = "R7"; tmo_cfg = 16'd0; pulse_start(); cycles(5000);
        check("R7", "zero limit idle", tmo_flag, 0);
        finish_run();
    end
endmodule